// File: doc/BRIEF.md
# DRAM Rank Boundary Decoder

This block turns a physical byte address into the memory rank that holds it. Software first loads a set of cumulative rank-boundary values: four per channel, two channels, each value counted in 64 MiB units. It also loads a top-of-memory value and a flag that limits the controller to one channel. From these the block works out each rank's size. It notices on its own when channel 1 is placed above channel 0 in the address map (stacked placement), and it then adjusts the sizes of the affected channel-1 ranks.

A lookup is a request pulse carrying a 36-bit address. A small scanner then walks the enabled ranks in ascending global order, one rank per cycle. It stops at the first rank that has a non-zero size and a boundary strictly above address bits 35:26. It answers with a one-cycle response: a hit flag, the channel, the rank within that channel, the global rank index and the rank's size. The scanner has three states. `ST_IDLE` waits for a request, and `req` takes it to `ST_SCAN`. `ST_SCAN` tests one rank per cycle and stays there while no rank matches and ranks remain. On a match, on an out-of-range address or after the last rank it moves to `ST_REPLY`. `ST_REPLY` presents the result for one cycle and always returns to `ST_IDLE`.

Top module: `rank_boundary_decoder`

## Requirements
- R1: After reset all boundaries, top of memory and the single-channel flag are zero, no response is pending, and any lookup returns a miss.
- R2: A write with `cfg_sel` 0..7 loads boundary for global rank `cfg_sel` (channel = sel/4, rank = sel%4). Select 8 loads top of memory and select 9 loads the single-channel flag from `cfg_wdata[0]`. Only `cfg_wdata[9:0]` is kept; bits 15:10 have no effect on any lookup.
- R3: Rank 0 of a channel has size equal to its boundary. Rank r>0 has size boundary[r] minus boundary[r-1], taken modulo 2^10.
- R4: Stacked placement holds when the boundary of channel 1 rank 3 equals top of memory. In that case each channel-1 rank whose boundary equals channel 1 rank 3's boundary has its size further reduced by channel 0 rank 3's boundary.
- R5: A hit reports the first rank, in ascending global index, whose size is non-zero and whose boundary is strictly greater than address bits 35:26. Zero-size ranks are skipped. The reported size is that rank's size.
- R6: An address whose bits 35:26 are at or above top of memory gives hit 0, with channel, rank, global index and size all 0.
- R7: With the single-channel flag set, only global ranks 0..3 are considered.
- R8: Each accepted request yields exactly one `rsp_valid` pulse, at most 10 cycles later. Requests made while `lk_busy` is high are ignored.
- R9: The global index equals channel*4 + rank. On a hit, `rsp_chan` is the index's top bit and `rsp_rank` is its low two bits.
- R10: An in-range address that matches no enabled rank gives a miss with all fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Target: 0..7 boundary, 8 top of memory, 9 single-channel flag |
| cfg_wdata | input | 16 | Write data; bits 9:0 used |
| lk_req | input | 1 | Lookup request, accepted when not busy |
| lk_addr | input | 36 | Physical byte address |
| lk_busy | output | 1 | Scanner is working on a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Address falls in a rank |
| rsp_chan | output | 1 | Channel of the hit rank |
| rsp_rank | output | 2 | Rank within the channel |
| rsp_gidx | output | 3 | Global rank index |
| rsp_size | output | 10 | Size of the hit rank in 64 MiB units |

## Verification
The assertions assume that configuration is not rewritten while a lookup is in flight. A hit checked against top of memory, or a size checked against the scanned boundaries, is only meaningful if those registers are stable. The stimulus therefore loads each full configuration while the scanner is idle. It then sweeps every 10-bit address unit from 0 to 1023 under that configuration. The configurations cover non-stacked dual channel, stacked placement, single channel and maximum-value boundaries. Requests during busy are issued only in a dedicated test, where exactly one response is expected.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    parameter int NCH    = 2;
    parameter int RPC    = 4;
    parameter int BW     = 10;
    parameter int ADDR_W = 36;

    localparam int NRANK    = NCH * RPC;
    localparam int GW       = $clog2(NRANK);
    localparam int CW       = $clog2(NCH);
    localparam int RW       = $clog2(RPC);
    localparam int GRAIN_SH = ADDR_W - BW;
    localparam int SEL_W    = 4;
    localparam int SEL_TOM  = NRANK;
    localparam int SEL_CFG  = NRANK + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_REPLY = 2'd2
    } rbd_state_e;
endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile
    import rbd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  logic [15:0]                wdata,
    output logic [NRANK-1:0][BW-1:0]   bnd,
    output logic [BW-1:0]              tom,
    output logic                       single
);
    logic [15-BW:0] unused_hi;
    assign unused_hi = wdata[15:BW];

    for (genvar g = 0; g < NRANK; g++) begin : g_bnd
        always_ff @(posedge clk) begin
            if (!rst_n)
                bnd[g] <= '0;
            else if (we && sel == SEL_W'(g))
                bnd[g] <= wdata[BW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tom    <= '0;
            single <= 1'b0;
        end else if (we) begin
            if (sel == SEL_W'(SEL_TOM)) tom    <= wdata[BW-1:0];
            if (sel == SEL_W'(SEL_CFG)) single <= wdata[0];
        end
    end

    assert_tom_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_W'(SEL_TOM)) |=> (tom == $past(wdata[BW-1:0])));
endmodule

// File: rtl/rbd_size_calc.sv
module rbd_size_calc
    import rbd_pkg::*;
(
    input  logic [NRANK-1:0][BW-1:0] bnd,
    input  logic [BW-1:0]            tom,
    output logic [NRANK-1:0][BW-1:0] size,
    output logic                     stacked
);
    assign stacked = (bnd[NRANK-1] == tom);

    for (genvar g = 0; g < NRANK; g++) begin : g_rank
        localparam int C = g / RPC;
        localparam int R = g % RPC;
        logic [BW-1:0] prev;
        logic [BW-1:0] cut;

        if (R == 0) begin : g_first
            assign prev = '0;
        end else begin : g_next
            assign prev = bnd[g-1];
        end

        if (C == NCH-1 && C > 0) begin : g_top
            assign cut = (stacked && bnd[g] == bnd[NRANK-1]) ? bnd[C*RPC-1] : '0;
        end else begin : g_low
            assign cut = '0;
        end

        assign size[g] = bnd[g] - prev - cut;
    end
endmodule

// File: rtl/rbd_scan_fsm.sv
module rbd_scan_fsm
    import rbd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic [BW-1:0]            unit_in,
    input  logic [NRANK-1:0][BW-1:0] bnd,
    input  logic [NRANK-1:0][BW-1:0] size,
    input  logic [BW-1:0]            tom,
    input  logic                     single,
    output logic                     busy,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [GW-1:0]            rsp_gidx,
    output logic [BW-1:0]            rsp_size
);
    rbd_state_e    state, state_nx;
    logic [BW-1:0] unit_q;
    logic [GW-1:0] idx;
    logic [GW-1:0] last_idx;
    logic          in_range, found;
    logic          res_hit;
    logic [GW-1:0] res_idx;
    logic [BW-1:0] res_size;

    assign last_idx = single ? GW'(RPC-1) : GW'(NRANK-1);
    assign in_range = unit_q < tom;
    assign found    = (size[idx] != '0) && (bnd[idx] > unit_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = ST_SCAN;
            ST_SCAN:  if (!in_range || found || idx == last_idx) state_nx = ST_REPLY;
            ST_REPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_q   <= '0;
            idx      <= '0;
            res_hit  <= 1'b0;
            res_idx  <= '0;
            res_size <= '0;
        end else begin
            if (state == ST_IDLE && req) begin
                unit_q <= unit_in;
                idx    <= '0;
            end else if (state == ST_SCAN) begin
                if (in_range && found) begin
                    res_hit  <= 1'b1;
                    res_idx  <= idx;
                    res_size <= size[idx];
                end else if (!in_range || idx == last_idx) begin
                    res_hit  <= 1'b0;
                    res_idx  <= '0;
                    res_size <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_gidx  = '0;
        rsp_size  = '0;
        unique case (state)
            ST_IDLE, ST_SCAN: ;
            ST_REPLY: begin
                rsp_valid = 1'b1;
                rsp_hit   = res_hit;
                rsp_gidx  = res_idx;
                rsp_size  = res_size;
            end
            default: ;
        endcase
    end

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_gidx == '0 && rsp_size == '0));
    assert_hit_below_tom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (unit_q < tom));
    assert_hit_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_size != '0 && bnd[rsp_gidx] > unit_q));
    assert_single_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && single) |-> (rsp_gidx < GW'(RPC)));
    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (idx <= last_idx));
endmodule

// File: rtl/rank_boundary_decoder.sv
module rank_boundary_decoder
    import rbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [CW-1:0]     rsp_chan,
    output logic [RW-1:0]     rsp_rank,
    output logic [GW-1:0]     rsp_gidx,
    output logic [BW-1:0]     rsp_size
);
    logic [NRANK-1:0][BW-1:0] bnd;
    logic [NRANK-1:0][BW-1:0] size;
    logic [BW-1:0]            tom;
    logic                     single;
    logic                     stacked;
    logic [GRAIN_SH-1:0]      unused_lo;

    assign unused_lo = lk_addr[GRAIN_SH-1:0];

    rbd_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .bnd    (bnd),
        .tom    (tom),
        .single (single)
    );

    rbd_size_calc u_size (
        .bnd     (bnd),
        .tom     (tom),
        .size    (size),
        .stacked (stacked)
    );

    rbd_scan_fsm u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lk_req),
        .unit_in   (lk_addr[ADDR_W-1 -: BW]),
        .bnd       (bnd),
        .size      (size),
        .tom       (tom),
        .single    (single),
        .busy      (lk_busy),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_gidx  (rsp_gidx),
        .rsp_size  (rsp_size)
    );

    assign rsp_chan = rsp_gidx[GW-1 -: CW];
    assign rsp_rank = rsp_gidx[RW-1:0];

    assert_stacked_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stacked && bnd[NRANK-1] != '0) |-> (size[NRANK-1] == bnd[NRANK-1] - bnd[NRANK-2] - bnd[RPC-1]));
endmodule

// File: tb/rank_boundary_decoder_test.sv
module rank_boundary_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        lk_req = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        lk_busy, rsp_valid, rsp_hit;
    logic        rsp_chan;
    logic [1:0]  rsp_rank;
    logic [2:0]  rsp_gidx;
    logic [9:0]  rsp_size;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [9:0] m_bnd [8];
    logic [9:0] m_tom;
    logic       m_single;

    rank_boundary_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_busy(lk_busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_chan(rsp_chan), .rsp_rank(rsp_rank), .rsp_gidx(rsp_gidx),
        .rsp_size(rsp_size)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 8) m_bnd[sel] = d[9:0];
        else if (sel == 8) m_tom = d[9:0];
        else if (sel == 9) m_single = d[0];
    endtask

    function automatic logic [9:0] exp_size(int g);
        logic [9:0] s;
        s = m_bnd[g] - ((g % 4 != 0) ? m_bnd[g-1] : 10'd0);
        if (m_bnd[7] == m_tom && g >= 4 && m_bnd[g] == m_bnd[7])
            s = s - m_bnd[3];
        return s;
    endfunction

    task automatic expect_lookup(input logic [9:0] unit, output logic hit,
                                 output logic [2:0] gi, output logic [9:0] sz);
        int top;
        hit = 1'b0; gi = '0; sz = '0;
        top = m_single ? 3 : 7;
        if (unit < m_tom) begin
            for (int g = 0; g <= top; g++) begin
                if (!hit && exp_size(g) != 0 && m_bnd[g] > unit) begin
                    hit = 1'b1; gi = 3'(g); sz = exp_size(g);
                end
            end
        end
    endtask

    task automatic lookup(input logic [35:0] addr, output logic ok, output logic h,
                          output logic [2:0] gi, output logic [9:0] sz,
                          output logic ch, output logic [1:0] rk);
        int n;
        ok = 1'b0; h = 0; gi = 0; sz = 0; ch = 0; rk = 0;
        @(negedge clk);
        lk_req = 1'b1; lk_addr = addr;
        @(negedge clk);
        lk_req = 1'b0;
        for (n = 0; n < 10 && !ok; n++) begin
            if (rsp_valid) begin
                ok = 1'b1; h = rsp_hit; gi = rsp_gidx; sz = rsp_size;
                ch = rsp_chan; rk = rsp_rank;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic probe(input logic [9:0] unit, input string tag);
        logic ok, h, eh, ch;
        logic [2:0] gi, egi;
        logic [9:0] sz, esz;
        logic [1:0] rk;
        expect_lookup(unit, eh, egi, esz);
        lookup({unit, 26'(unit * 16'h9e37)}, ok, h, gi, sz, ch, rk);
        check({tag, " R8 response"}, 32'(ok), 32'd1);
        check({tag, " R5 hit"}, 32'(h), 32'(eh));
        check({tag, " R5 gidx"}, 32'(gi), 32'(egi));
        check({tag, " R3 size"}, 32'(sz), 32'(esz));
        check({tag, " R9 split"}, 32'({ch, rk}), 32'(gi));
    endtask

    task automatic sweep(input string tag);
        for (int u = 0; u < 1024; u++) probe(10'(u), tag);
    endtask

    initial begin
        logic ok, h, ch;
        logic [2:0] gi;
        logic [9:0] sz;
        logic [1:0] rk;
        int pulses;
        for (int i = 0; i < 8; i++) m_bnd[i] = '0;
        m_tom = '0; m_single = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        check("R1 busy idle", 32'(lk_busy), 32'd0);
        lookup(36'h0, ok, h, gi, sz, ch, rk);
        check("R1 reset lookup miss", 32'({ok, h, gi, sz}), 32'({1'b1, 1'b0, 3'd0, 10'd0}));

        // Config A: dual channel, not stacked; upper data bits set (R2)
        wr(0, 16'hfc04); wr(1, 16'h8408); wr(2, 16'h0408); wr(3, 16'hfc10);
        wr(4, 16'h7c02); wr(5, 16'h0002); wr(6, 16'hf806); wr(7, 16'h000a);
        wr(8, 16'hfc1a); wr(9, 16'hfffe);
        lookup({10'd5, 26'h1}, ok, h, gi, sz, ch, rk);
        check("R3 rank1 size diff", 32'({h, gi, sz}), 32'({1'b1, 3'd1, 10'd4}));
        lookup({10'd26, 26'h0}, ok, h, gi, sz, ch, rk);
        check("R6 at top of memory", 32'({h, ch, rk, gi, sz}), 32'd0);
        lookup({10'd20, 26'h0}, ok, h, gi, sz, ch, rk);
        check("R10 no rank matches", 32'({h, gi, sz}), 32'd0);
        lookup({10'd1, 26'h0}, ok, h, gi, sz, ch, rk);
        check("R2 upper bits ignored", 32'({h, gi, sz}), 32'({1'b1, 3'd0, 10'd4}));
        sweep("cfgA");

        // Busy test (R8)
        @(negedge clk);
        lk_req = 1'b1; lk_addr = {10'd9, 26'h0};
        @(negedge clk);
        lk_req = 1'b1; lk_addr = {10'd1, 26'h0};
        check("R8 busy after accept", 32'(lk_busy), 32'd1);
        @(negedge clk);
        lk_req = 1'b0;
        pulses = 0;
        for (int n = 0; n < 25; n++) begin
            if (rsp_valid) begin
                pulses++;
                check("R8 first request answered", 32'({rsp_hit, rsp_gidx, rsp_size}),
                      32'({1'b1, 3'd3, 10'd8}));
            end
            @(negedge clk);
        end
        check("R8 single pulse", 32'(pulses), 32'd1);

        // Config B: stacked
        wr(0, 16'd4); wr(1, 16'd8); wr(2, 16'd12); wr(3, 16'd16);
        wr(4, 16'd20); wr(5, 16'd24); wr(6, 16'd24); wr(7, 16'd40);
        wr(8, 16'd40);
        lookup({10'd30, 26'h0}, ok, h, gi, sz, ch, rk);
        check("R4 stacked rank3 reduced to zero, skipped", 32'({h, gi, sz}), 32'd0);
        lookup({10'd17, 26'h0}, ok, h, gi, sz, ch, rk);
        check("R4 stacked ch1 rank0", 32'({h, ch, rk, sz}), 32'({1'b1, 1'b1, 2'd0, 10'd20}));
        sweep("cfgB");

        // Config C: single channel
        wr(0, 16'd4); wr(1, 16'd8); wr(2, 16'd8); wr(3, 16'd16);
        wr(4, 16'd30); wr(5, 16'd40); wr(6, 16'd50); wr(7, 16'd60);
        wr(8, 16'd100); wr(9, 16'h0001);
        lookup({10'd20, 26'h0}, ok, h, gi, sz, ch, rk);
        check("R7 channel 1 ignored", 32'({h, gi, sz}), 32'd0);
        sweep("cfgC");

        // Config D: extreme values, dual channel
        wr(9, 16'h0000);
        wr(0, 16'd0); wr(1, 16'd0); wr(2, 16'd0); wr(3, 16'd1023);
        wr(4, 16'd0); wr(5, 16'd0); wr(6, 16'd0); wr(7, 16'd0);
        wr(8, 16'd1023);
        lookup({10'd1022, 26'h3ffffff}, ok, h, gi, sz, ch, rk);
        check("R5 last unit below top", 32'({h, gi, sz}), 32'({1'b1, 3'd3, 10'd1023}));
        lookup({10'd1023, 26'h0}, ok, h, gi, sz, ch, rk);
        check("R6 max unit miss", 32'({h, gi, sz}), 32'd0);
        sweep("cfgD");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule